// File: doc/BRIEF.md
# Policy-Configurable Direct-Mapped Data Cache

This block sits between one word-wide requester and a slower memory that moves a whole line per transfer. It is direct-mapped: 16 lines of four 32-bit words. A 32-bit address splits into a tag (bits 31:8), a line index (bits 7:4), a word select (bits 3:2) and a byte offset (bits 1:0). Each line stores a tag, a valid flag and a dirty flag.

Two static inputs set the write behaviour. `cfg_wb` picks copy-back (1) or store-through (0). `cfg_walloc` picks whether a write miss brings the line in (1) or goes straight to memory (0). A read miss always brings the line in. Two maintenance commands exist. The flush command writes every modified line out and keeps it resident. The drop command discards all lines and writes nothing.

On both ports a request is held until the matching ready. On the memory port, a line-wide beat carries word k in bits [32k+31:32k]. Strobe bit 4k+b covers byte b of word k.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset every line is invalid and clean. `busy`, `cpu_ready` and `mem_valid` are low while no request is present. The first read of each line therefore fetches it from memory.
- R2: A read that hits completes (`cpu_ready` high) in the cycle it is presented. It returns the stored word and raises no memory request.
- R3: A read miss issues one memory read at the line-aligned address and installs the returned line. The read then completes from that line, and the other three words of the line then hit.
- R4: In store-through mode a write hit updates the cached word and forwards the write to memory as one request. That request strobes only the written bytes of the addressed word. The write completes when memory accepts it, and the line is never marked modified.
- R5: In copy-back mode a write hit updates only the cached line, marks it modified, completes in the same cycle and raises no memory request.
- R6: With write allocation on, a write miss first fetches the line and then applies the write. In copy-back mode the line becomes modified; in store-through mode the write also goes to memory.
- R7: With write allocation off, a write miss goes directly to memory with byte strobes. The cache is left unchanged, so a later read of that address misses.
- R8: Before a modified line is replaced, the whole line is written to memory with all strobes, at the address built from its stored tag, and its dirty flag is cleared. A clean victim is not written.
- R9: The flush command writes each valid modified line to memory once and clears its dirty flag. The line stays valid with its data, so an immediate second flush writes nothing.
- R10: The drop command clears every valid and dirty flag and performs no memory write. Later reads fetch from memory again.
- R11: A command is taken only in a cycle with no request from the requester; otherwise it is ignored. `busy` is high from the next cycle until the walk over all 16 lines ends (exactly 16 cycles for a drop), and `cpu_ready` stays low while `busy` is high.
- R12: A write changes only the bytes whose `cpu_be` bit is set.
- R13: Once `mem_valid` is raised, it stays high with stable address, direction and data until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wb | input | 1 | 1 = copy-back, 0 = store-through |
| cfg_walloc | input | 1 | 1 = allocate on write miss |
| cpu_req | input | 1 | Requester access valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte strobes for writes |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cmd_clean | input | 1 | Flush command pulse |
| cmd_inval | input | 1 | Drop command pulse |
| busy | output | 1 | Maintenance walk in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line write data |
| mem_be | output | 16 | Line byte strobes |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | 128 | Line read data, valid with `mem_ready` |

## Verification
Reads sweep every word of every line twice. The first pass separates the one fetch per line from the hits on its neighbours; the second shows that nothing is refetched. Writes sweep every word with strobe patterns that rotate through all fifteen non-zero values. They run under each of the four policy combinations and compare the memory image against the bench's running model. This shows whether data stayed local or reached memory, and whether only strobed bytes moved. Conflicting tags force replacement of both modified and clean victims. Flush and drop runs are counted by memory writes and by walk length, and one command is presented together with a request to show that it is ignored.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_WRMEM, S_EVICT, S_FILL, S_CLEAN, S_INVAL
    } dc_state_e;

    typedef enum logic [2:0] {
        F_NONE, F_FILL, F_DIRTY, F_CLEAN, F_KILL
    } dc_flag_op_e;
endpackage

// File: rtl/dc_flags.sv
`timescale 1ns/1ps
module dc_flags
    import dc_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dc_flag_op_e       op,
    input  logic [IDX_W-1:0]  op_idx,
    output logic [LINES-1:0]  valid_o,
    output logic [LINES-1:0]  dirty_o
);
    typedef struct packed {
        logic [LINES-1:0] v;
        logic [LINES-1:0] d;
    } flags_t;

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        unique case (op)
            F_FILL:  begin fl_d.v[op_idx] = 1'b1; fl_d.d[op_idx] = 1'b0; end
            F_DIRTY: fl_d.d[op_idx] = 1'b1;
            F_CLEAN: fl_d.d[op_idx] = 1'b0;
            F_KILL:  begin fl_d.v[op_idx] = 1'b0; fl_d.d[op_idx] = 1'b0; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign valid_o = fl_q.v;
    assign dirty_o = fl_q.d;
endmodule

// File: rtl/dc_line_store.sv
`timescale 1ns/1ps
module dc_line_store #(
    parameter int LINES  = 16,
    parameter int IDX_W  = 4,
    parameter int LINE_W = 128,
    parameter int TAG_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    output logic [TAG_W-1:0]  rd_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [TAG_W-1:0]  wr_tag
);
    logic [LINE_W-1:0] data_d [LINES];
    logic [LINE_W-1:0] data_q [LINES];
    logic [TAG_W-1:0]  tag_d  [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];

    always_comb begin
        data_d = data_q;
        tag_d  = tag_q;
        if (wr_en) begin
            data_d[wr_idx] = wr_line;
            tag_d[wr_idx]  = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                data_q[i] <= '0;
                tag_q[i]  <= '0;
            end
        end else begin
            data_q <= data_d;
            tag_q  <= tag_d;
        end
    end

    assign rd_line = data_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
endmodule

// File: rtl/dcache_ctrl.sv
`timescale 1ns/1ps
module dcache_ctrl
    import dc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LINES = 16,
    parameter int WORDS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wb,
    input  logic                    cfg_walloc,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [AW-1:0]           cpu_addr,
    input  logic [DW-1:0]           cpu_wdata,
    input  logic [DW/8-1:0]         cpu_be,
    output logic                    cpu_ready,
    output logic [DW-1:0]           cpu_rdata,
    input  logic                    cmd_clean,
    input  logic                    cmd_inval,
    output logic                    busy,
    output logic                    mem_valid,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [DW*WORDS-1:0]     mem_wdata,
    output logic [DW*WORDS/8-1:0]   mem_be,
    input  logic                    mem_ready,
    input  logic [DW*WORDS-1:0]     mem_rdata
);
    localparam int BE_W   = DW / 8;
    localparam int BOFF_W = $clog2(BE_W);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = AW - IDX_W - OFF_W - BOFF_W;
    localparam int LINE_W = DW * WORDS;
    localparam int LBE_W  = LINE_W / 8;

    typedef struct packed {
        dc_state_e        st;
        logic [IDX_W-1:0] walk;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [OFF_W-1:0]  a_off;
    logic [IDX_W-1:0]  rd_idx;
    logic [LINE_W-1:0] rd_line, merged, st_wr_line;
    logic [TAG_W-1:0]  rd_tag;
    logic              st_wr_en;
    logic [LINES-1:0]  valid_v, dirty_v;
    dc_flag_op_e       fl_op;
    logic [IDX_W-1:0]  fl_idx;
    logic              hit, vic_dirty, walking, adv;

    function automatic logic [AW-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                input logic [IDX_W-1:0] i);
        return {t, i, {(OFF_W + BOFF_W){1'b0}}};
    endfunction

    assign a_tag     = cpu_addr[AW-1 -: TAG_W];
    assign a_idx     = cpu_addr[BOFF_W+OFF_W +: IDX_W];
    assign a_off     = cpu_addr[BOFF_W +: OFF_W];
    assign walking   = (ctl_q.st == S_CLEAN) || (ctl_q.st == S_INVAL);
    assign rd_idx    = walking ? ctl_q.walk : a_idx;
    assign hit       = valid_v[a_idx] && (rd_tag == a_tag);
    assign vic_dirty = valid_v[a_idx] && dirty_v[a_idx];
    assign busy      = walking;
    assign cpu_rdata = rd_line[int'(a_off)*DW +: DW];

    always_comb begin
        merged = rd_line;
        for (int b = 0; b < BE_W; b++) begin
            if (cpu_be[b]) merged[int'(a_off)*DW + b*8 +: 8] = cpu_wdata[b*8 +: 8];
        end
    end

    dc_line_store #(.LINES(LINES), .IDX_W(IDX_W), .LINE_W(LINE_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_line(rd_line), .rd_tag(rd_tag),
        .wr_en(st_wr_en), .wr_idx(a_idx), .wr_line(st_wr_line), .wr_tag(a_tag)
    );

    dc_flags #(.LINES(LINES), .IDX_W(IDX_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .op(fl_op), .op_idx(fl_idx),
        .valid_o(valid_v), .dirty_o(dirty_v)
    );

    always_comb begin
        ctl_d      = ctl_q;
        cpu_ready  = 1'b0;
        mem_valid  = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        mem_be     = '0;
        st_wr_en   = 1'b0;
        st_wr_line = merged;
        fl_op      = F_NONE;
        fl_idx     = a_idx;
        adv        = 1'b0;
        unique case (ctl_q.st)
            S_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        if (!cpu_we) begin
                            cpu_ready = 1'b1;
                        end else if (cfg_wb) begin
                            cpu_ready = 1'b1;
                            st_wr_en  = 1'b1;
                            fl_op     = F_DIRTY;
                        end else begin
                            ctl_d.st = S_WRMEM;
                        end
                    end else if (cpu_we && !cfg_walloc) begin
                        ctl_d.st = S_WRMEM;
                    end else if (vic_dirty) begin
                        ctl_d.st = S_EVICT;
                    end else begin
                        ctl_d.st = S_FILL;
                    end
                end else if (cmd_clean) begin
                    ctl_d.st   = S_CLEAN;
                    ctl_d.walk = '0;
                end else if (cmd_inval) begin
                    ctl_d.st   = S_INVAL;
                    ctl_d.walk = '0;
                end
            end
            S_WRMEM: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = line_addr(a_tag, a_idx);
                mem_wdata = {WORDS{cpu_wdata}};
                mem_be    = LBE_W'(cpu_be) << (int'(a_off) * BE_W);
                if (mem_ready) begin
                    cpu_ready = 1'b1;
                    st_wr_en  = hit;
                    ctl_d.st  = S_IDLE;
                end
            end
            S_EVICT: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = line_addr(rd_tag, a_idx);
                mem_wdata = rd_line;
                mem_be    = '1;
                if (mem_ready) begin
                    fl_op    = F_CLEAN;
                    ctl_d.st = S_FILL;
                end
            end
            S_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = line_addr(a_tag, a_idx);
                if (mem_ready) begin
                    st_wr_en   = 1'b1;
                    st_wr_line = mem_rdata;
                    fl_op      = F_FILL;
                    ctl_d.st   = S_IDLE;
                end
            end
            S_CLEAN: begin
                fl_idx = ctl_q.walk;
                if (valid_v[ctl_q.walk] && dirty_v[ctl_q.walk]) begin
                    mem_valid = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = line_addr(rd_tag, ctl_q.walk);
                    mem_wdata = rd_line;
                    mem_be    = '1;
                    if (mem_ready) begin
                        fl_op = F_CLEAN;
                        adv   = 1'b1;
                    end
                end else begin
                    adv = 1'b1;
                end
            end
            S_INVAL: begin
                fl_idx = ctl_q.walk;
                fl_op  = F_KILL;
                adv    = 1'b1;
            end
            default: ctl_d.st = S_IDLE;
        endcase
        if (adv) begin
            if (ctl_q.walk == IDX_W'(LINES - 1)) ctl_d.st = S_IDLE;
            else                                 ctl_d.walk = ctl_q.walk + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: S_IDLE, walk: '0};
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/dc_checker.sv
`timescale 1ns/1ps
module dc_checker #(
    parameter int AW     = 32,
    parameter int LINE_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wb,
    input logic              cfg_walloc,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [AW-1:0]     cpu_addr,
    input logic              cpu_ready,
    input logic              busy,
    input logic              mem_valid,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [AW-1:0]     mem_addr,
    input logic [LINE_W-1:0] mem_wdata
);
    // R2: completion only answers a request, and the request is held until then
    a_r2_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ready) |=> (cpu_req && $stable(cpu_addr) && $stable(cpu_we)));
    // R2: a read completes without a memory request in flight
    a_r2_read_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_ready) |-> !mem_valid);
    // R4: a store-through write completes together with its memory write
    a_r4_wt_reaches_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wb && cpu_req && cpu_we && cpu_ready) |-> (mem_valid && mem_we && mem_ready));
    // R5: copy-back with allocation never completes a write on the memory port
    a_r5_wb_local: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wb && cfg_walloc && cpu_req && cpu_we && cpu_ready) |-> !mem_valid);
    // R11: no completion during a walk; no walk starts beside a request
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cpu_ready);
    a_r11_req_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !busy) |=> !busy);
    // R13: memory request held stable until accepted
    a_r13_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                       $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind dcache_ctrl dc_checker #(.AW(AW), .LINE_W(DW*WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wb(cfg_wb), .cfg_walloc(cfg_walloc),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
    .busy(busy), .mem_valid(mem_valid), .mem_we(mem_we), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/sim_dcache_ctrl.sv
`timescale 1ns/1ps
module sim_dcache_ctrl;
    logic         clk = 0, rst_n = 0;
    logic         cfg_wb = 1, cfg_walloc = 1;
    logic         cpu_req = 0, cpu_we = 0;
    logic [31:0]  cpu_addr = 0, cpu_wdata = 0;
    logic [3:0]   cpu_be = 0;
    logic         cpu_ready;
    logic [31:0]  cpu_rdata;
    logic         cmd_clean = 0, cmd_inval = 0, busy;
    logic         mem_valid, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata, mem_rdata = 0;
    logic [15:0]  mem_be;
    logic         mem_ready = 0;

    always #10 clk = ~clk;

    dcache_ctrl u0 (.*);

    logic [31:0] mm   [256];
    logic [31:0] gold [256];
    int n_cmp = 0, n_bad = 0, rd_cnt = 0, wr_cnt = 0, dly = 0;
    int waits, len, r0, w0, seen;
    logic [31:0] rd;

    function automatic logic [31:0] minit(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0001_0003;
    endfunction
    function automatic logic [31:0] ad(input int t, input int i, input int w);
        return 32'(t*256 + i*16 + w*4);
    endfunction

    // memory model: accepts a request on its second negedge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 0; dly = 0;
        end else if (mem_ready) begin
            mem_ready = 0; dly = 0;
        end else if (mem_valid) begin
            if (dly == 1) begin
                if (mem_we) begin
                    for (int b = 0; b < 16; b++)
                        if (mem_be[b]) mm[int'(mem_addr[9:4])*4 + b/4][(b%4)*8 +: 8] = mem_wdata[b*8 +: 8];
                    wr_cnt++;
                end else begin
                    for (int w = 0; w < 4; w++) mem_rdata[w*32 +: 32] = mm[int'(mem_addr[9:4])*4 + w];
                    rd_cnt++;
                end
                mem_ready = 1;
            end else dly++;
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          input logic [3:0] be);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        waits = 0;
        #1;
        while (!cpu_ready && waits < 2000) begin @(negedge clk); #1; waits++; end
        if (waits >= 2000) check("R2 request hang", 0, 1);
        rd = cpu_rdata;
        if (we) for (int b = 0; b < 4; b++) if (be[b]) gold[a[9:2]][b*8 +: 8] = wd[b*8 +: 8];
        @(posedge clk); #1 cpu_req = 0;
    endtask

    task automatic do_cmd(input bit clean);
        @(negedge clk);
        if (clean) cmd_clean = 1; else cmd_inval = 1;
        @(negedge clk);
        cmd_clean = 0; cmd_inval = 0; len = 0;
        #1;
        while (busy && len < 10000) begin len++; @(negedge clk); #1; end
    endtask

    task automatic mem_vs_gold(input string rq);
        for (int i = 0; i < 256; i++) if (mm[i] !== gold[i]) check(rq, mm[i], gold[i]);
        n_cmp++;
    endtask

    initial begin
        #(20 * 150000);
        check("watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin mm[i] = minit(i); gold[i] = minit(i); end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        check("R1 busy after reset", {31'b0, busy}, 0);
        check("R1 ready after reset", {31'b0, cpu_ready}, 0);
        check("R1 mem_valid after reset", {31'b0, mem_valid}, 0);

        // R1/R2/R3: read sweep, one fetch per line
        for (int i = 0; i < 16; i++)
            for (int w = 0; w < 4; w++) begin
                cpu_op(0, ad(0, i, w), 0, 0);
                check("R3 read miss data", rd, gold[ad(0, i, w) >> 2]);
                if (w != 0) check("R3 rest of line hits", 32'(waits), 0);
            end
        check("R1 one fetch per line", 32'(rd_cnt), 16);
        for (int i = 0; i < 64; i++) begin
            cpu_op(0, 32'(i*4), 0, 0);
            check("R2 read hit data", rd, gold[i]);
            check("R2 read hit latency", 32'(waits), 0);
        end
        check("R2 no refetch", 32'(rd_cnt), 16);

        // R5/R12: copy-back writes with rotating strobes
        for (int i = 0; i < 64; i++)
            cpu_op(1, 32'(i*4), 32'hC0DE_0000 ^ (32'(i) * 32'h9E37_79B9), 4'((i % 15) + 1));
        check("R5 no memory write", 32'(wr_cnt), 0);
        check("R5 memory unchanged", mm[1], minit(1));
        for (int i = 0; i < 64; i++) begin
            cpu_op(0, 32'(i*4), 0, 0);
            check("R12 strobed merge", rd, gold[i]);
        end

        // R9: flush writes all dirty lines, keeps them
        do_cmd(1);
        check("R9 flush writes", 32'(wr_cnt), 16);
        mem_vs_gold("R9 memory after flush");
        for (int i = 0; i < 64; i++) cpu_op(0, 32'(i*4), 0, 0);
        check("R9 lines kept valid", 32'(rd_cnt), 16);
        do_cmd(1);
        check("R9 second flush idle", 32'(wr_cnt), 16);

        // R8: replacement of dirty and clean victims
        cpu_op(1, ad(0, 3, 0), 32'h1234_5678, 4'hF);
        w0 = wr_cnt; r0 = rd_cnt;
        cpu_op(0, ad(1, 3, 2), 0, 0);
        check("R8 conflict read data", rd, gold[ad(1, 3, 2) >> 2]);
        check("R8 dirty victim written", 32'(wr_cnt), 32'(w0 + 1));
        check("R8 fill after evict", 32'(rd_cnt), 32'(r0 + 1));
        check("R8 victim data in memory", mm[ad(0, 3, 0) >> 2], 32'h1234_5678);
        cpu_op(0, ad(0, 3, 1), 0, 0);
        check("R8 clean victim not written", 32'(wr_cnt), 32'(w0 + 1));
        check("R8 refetch data", rd, gold[ad(0, 3, 1) >> 2]);

        // R4: store-through hits
        cfg_wb = 0;
        w0 = wr_cnt; r0 = rd_cnt;
        cpu_op(1, ad(0, 3, 1), 32'hAABB_CCDD, 4'b0110);
        check("R4 partial word to memory", mm[ad(0, 3, 1) >> 2], gold[ad(0, 3, 1) >> 2]);
        check("R4 one memory write", 32'(wr_cnt), 32'(w0 + 1));
        for (int i = 0; i < 16; i++) begin
            cpu_op(1, ad(0, i, 2), 32'h5A00_0000 + 32'(i), 4'hF);
            check("R4 word to memory", mm[ad(0, i, 2) >> 2], gold[ad(0, i, 2) >> 2]);
        end
        check("R4 no fetch on hit", 32'(rd_cnt), 32'(r0));
        w0 = wr_cnt;
        do_cmd(1);
        check("R4 never dirty", 32'(wr_cnt), 32'(w0));

        // R6: allocate on write miss, both modes
        w0 = wr_cnt; r0 = rd_cnt;
        cpu_op(1, ad(2, 5, 3), 32'h0F0F_0F0F, 4'hF);
        check("R6 wt alloc fetch", 32'(rd_cnt), 32'(r0 + 1));
        check("R6 wt alloc forwarded", mm[ad(2, 5, 3) >> 2], 32'h0F0F_0F0F);
        cpu_op(0, ad(2, 5, 3), 0, 0);
        check("R6 wt alloc resident", 32'(waits), 0);
        cfg_wb = 1;
        w0 = wr_cnt; r0 = rd_cnt;
        cpu_op(1, ad(3, 6, 0), 32'hFACE_B00C, 4'hF);
        check("R6 wb alloc fetch", 32'(rd_cnt), 32'(r0 + 1));
        check("R6 wb alloc no write", 32'(wr_cnt), 32'(w0));
        check("R6 wb memory untouched", mm[ad(3, 6, 0) >> 2], minit(ad(3, 6, 0) >> 2));
        cpu_op(0, ad(3, 6, 0), 0, 0);
        check("R6 wb alloc data", rd, 32'hFACE_B00C);
        do_cmd(1);
        check("R6 wb alloc line dirty", 32'(wr_cnt), 32'(w0 + 1));
        mem_vs_gold("R6 memory after flush");

        // R7: no allocation on write miss
        cfg_walloc = 0;
        foreach_mode: for (int m = 0; m < 2; m++) begin
            cfg_wb = (m == 0);
            w0 = wr_cnt; r0 = rd_cnt;
            cpu_op(1, ad(1 + m, 7 + m, 1), 32'h7777_0000 + 32'(m), 4'b1001);
            check("R7 direct write", 32'(wr_cnt), 32'(w0 + 1));
            check("R7 no fetch", 32'(rd_cnt), 32'(r0));
            check("R7 memory updated", mm[ad(1 + m, 7 + m, 1) >> 2], gold[ad(1 + m, 7 + m, 1) >> 2]);
            cpu_op(0, ad(1 + m, 7 + m, 1), 0, 0);
            check("R7 cache unchanged", 32'(rd_cnt), 32'(r0 + 1));
            check("R7 read data", rd, gold[ad(1 + m, 7 + m, 1) >> 2]);
        end

        // R10/R11: drop discards dirty data, walk is 16 cycles
        cfg_wb = 1; cfg_walloc = 1;
        cpu_op(1, ad(0, 0, 0), 32'hDEAD_BEEF, 4'hF);
        w0 = wr_cnt; r0 = rd_cnt;
        do_cmd(0);
        check("R11 drop walk length", 32'(len), 16);
        check("R10 no write-back", 32'(wr_cnt), 32'(w0));
        gold[0] = mm[0];
        cpu_op(0, ad(0, 0, 0), 0, 0);
        check("R10 refetch", 32'(rd_cnt), 32'(r0 + 1));
        check("R10 old memory data", rd, mm[0]);

        // R11: command beside a request is ignored
        cpu_op(1, ad(0, 0, 1), 32'h0BAD_F00D, 4'hF);
        w0 = wr_cnt;
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = ad(0, 0, 2); cmd_clean = 1;
        #1;
        check("R11 hit beside command", {31'b0, cpu_ready}, 1);
        check("R11 read data", cpu_rdata, gold[2]);
        @(posedge clk); #1 cpu_req = 0; cmd_clean = 0;
        seen = 0;
        repeat (3) begin @(negedge clk); #1; if (busy) seen++; end
        check("R11 command ignored", 32'(seen), 0);
        check("R11 no flush write", 32'(wr_cnt), 32'(w0));
        do_cmd(1);
        check("R9 later flush", 32'(wr_cnt), 32'(w0 + 1));
        mem_vs_gold("R9 final memory");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule